// File: doc/BRIEF.md
# Occupancy-Driven Adaptive Clock Selector

This block chooses the operating rate of a downstream packet classifier from how full its input packet buffer is. It runs from a fast reference clock and keeps a current frequency state. State i runs at the reference rate divided by 2^(NST-1-i), so the top state runs at the full reference rate and each lower state runs at half the rate of the one above it. The chosen rate is delivered as a train of one-cycle clock-enable pulses, which a clock gate or a set of enabled flops downstream can use.

Software programs an exit threshold for every state except the top one. Each threshold is a cumulative buffer level, and it may be rewritten at any time. A mask says which states are in use. When the buffer level is above the threshold of the current state, the block climbs to the next enabled state. When the level is at or below the threshold of the enabled state just below, it steps back down. Masked-off states are skipped in both directions. The state moves by at most one enabled step per reference cycle. Whenever the state changes, the divide counter restarts, so no pulse interval is ever shorter than the new state's period.

Top module: `occ_clk_sel`

## Requirements
- R1: While `rst_n` is low, `state_idx` is 0 and `clk_en` is 0. At any clock edge where the current state is not enabled in `state_mask` and the mask is not all zero, the state moves to the lowest enabled state. One cycle after reset is released, the block is therefore in the lowest enabled state.
- R2: All thresholds reset to all-ones, so no climb happens until they are programmed. A write with `thr_wr_en` high and `thr_wr_idx` below NST-1 replaces threshold `thr_wr_idx`, and that new value is used for decisions from the next clock edge onward.
- R3: If the current state is enabled, some enabled state lies above it, and `occ_level` is strictly greater than the current state's threshold, the state moves to the lowest enabled state above it.
- R4: If R3 does not apply and some enabled state lies below the current state, and `occ_level` is less than or equal to the threshold of the highest enabled state below it, the state moves to that state.
- R5: Disabled states are never entered. A move skips over them to the nearest enabled state. With an all-zero mask, the state holds.
- R6: At most one transition happens per clock edge, and a transition never passes over an enabled state.
- R7: In state i, `clk_en` is a one-cycle pulse repeating every 2^(NST-1-i) reference cycles. In the top state NST-1, it is high in every cycle.
- R8: On every state change, the divide count restarts. The first pulse in the new state i appears in the 2^(NST-1-i)-th cycle spent in that state, counting the first cycle as 1.
- R9: `state_idx` is the 4-bit binary index of the current state and is always below NST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_level | input | OCC_W | Current packet buffer occupancy |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_idx | input | 4 | State whose exit threshold is written; values of NST-1 or more are dropped |
| thr_wr_val | input | OCC_W | New cumulative threshold value |
| state_mask | input | NST | Bit i set means state i is in use |
| clk_en | output | 1 | Divided-rate clock-enable pulse |
| state_idx | output | 4 | Current frequency state |

## Verification
The bench goes after the following corner cases:
- A climb from the bottom state to the top under a large occupancy must take exactly one cycle per state. A design that jumped straight to the target state would show the top index after a single cycle.
- A sparse mask must make the block realign to the lowest enabled state and then skip gaps. A design that ignored the mask would stop in unused states.
- A threshold rewritten while the state is held must change the very next decision. A design that latched thresholds late would hold one cycle too long.
- The first pulse after a change must fall exactly one period after the change, and an all-zero mask must freeze the state. A divider that kept its old count would pulse early, and a selector with no empty-mask guard would wander.

// File: rtl/ocs_pkg.sv
`timescale 1ns/1ps
package ocs_pkg;
  localparam int MAXS  = 16;
  localparam int IDX_W = 4;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } pick_t;

  // lowest set bit of the mask
  function automatic pick_t pick_lowest(logic [MAXS-1:0] en);
    pick_t r;
    r = '0;
    for (int k = MAXS-1; k >= 0; k--)
      if (en[k]) begin
        r.hit = 1'b1;
        r.idx = idx_t'(k);
      end
    return r;
  endfunction

  // nearest set bit strictly above cur
  function automatic pick_t pick_above(logic [MAXS-1:0] en, idx_t cur);
    pick_t r;
    r = '0;
    for (int k = MAXS-1; k >= 0; k--)
      if (en[k] && k > int'(cur)) begin
        r.hit = 1'b1;
        r.idx = idx_t'(k);
      end
    return r;
  endfunction

  // nearest set bit strictly below cur
  function automatic pick_t pick_below(logic [MAXS-1:0] en, idx_t cur);
    pick_t r;
    r = '0;
    for (int k = 0; k < MAXS; k++)
      if (en[k] && k < int'(cur)) begin
        r.hit = 1'b1;
        r.idx = idx_t'(k);
      end
    return r;
  endfunction

  // terminal count of the divider: 2^(nst-1-cur) - 1
  function automatic logic [MAXS-1:0] div_last(int nst, idx_t cur);
    int sh;
    logic [MAXS-1:0] one;
    one = 1;
    sh  = nst - 1 - int'(cur);
    if (sh < 0) sh = 0;
    return (one << sh) - one;
  endfunction
endpackage

// File: rtl/ocs_thr_bank.sv
`timescale 1ns/1ps
module ocs_thr_bank
  import ocs_pkg::*;
#(
  parameter int NST   = 10,
  parameter int OCC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  idx_t                          wr_idx,
  input  logic [OCC_W-1:0]              wr_val,
  output logic [NST-2:0][OCC_W-1:0]     thr_q
);
  for (genvar g = 0; g < NST-1; g++) begin : g_thr
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == idx_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     thr_q[g] <= '1;
      else if (hit_w) thr_q[g] <= wr_val;
    end

    // R2: a write lands in the addressed slot by the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == idx_t'(g)) |=> thr_q[g] == $past(wr_val));
  end
endmodule

// File: rtl/ocs_step_ctrl.sv
`timescale 1ns/1ps
module ocs_step_ctrl
  import ocs_pkg::*;
#(
  parameter int NST   = 10,
  parameter int OCC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OCC_W-1:0]          occ,
  input  logic [NST-2:0][OCC_W-1:0] thr_q,
  input  logic [NST-1:0]            en,
  output idx_t                      cur_q,
  output logic                      cur_chg,
  output logic                      ev_up,
  output logic                      ev_dn,
  output logic                      ev_align
);
  logic [MAXS-1:0] en_w;
  pick_t           lo_any, up_p, dn_p;
  logic [OCC_W-1:0] thr_cur, thr_dn;
  logic            cur_on;
  idx_t            nxt;

  always_comb begin
    en_w = '0;
    en_w[NST-1:0] = en;
  end

  assign lo_any = pick_lowest(en_w);
  assign up_p   = pick_above(en_w, cur_q);
  assign dn_p   = pick_below(en_w, cur_q);
  assign cur_on = en_w[cur_q];

  always_comb begin
    thr_cur = '1;
    thr_dn  = '1;
    for (int k = 0; k < NST-1; k++) begin
      if (cur_q == idx_t'(k))    thr_cur = thr_q[k];
      if (dn_p.idx == idx_t'(k)) thr_dn  = thr_q[k];
    end
  end

  // named decision events
  assign ev_align = !cur_on && lo_any.hit;
  assign ev_up    = cur_on && up_p.hit && (occ > thr_cur);
  assign ev_dn    = cur_on && !ev_up && dn_p.hit && (occ <= thr_dn);
  assign cur_chg  = ev_align || ev_up || ev_dn;

  always_comb begin
    nxt = cur_q;
    if (ev_align)   nxt = lo_any.idx;
    else if (ev_up) nxt = up_p.idx;
    else if (ev_dn) nxt = dn_p.idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  a_r3_up_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up |=> cur_q > $past(cur_q));

  a_r4_dn_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dn |=> cur_q < $past(cur_q));

  a_r5_lands_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cur_chg |=> (en_w[cur_q] || !$stable(en)));

  a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_align, ev_up, ev_dn}));

  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_q) < NST);
endmodule

// File: rtl/ocs_rate_div.sv
`timescale 1ns/1ps
module ocs_rate_div
  import ocs_pkg::*;
#(
  parameter int NST = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  idx_t cur,
  input  logic restart,
  output logic clk_en
);
  localparam int DIV_W = NST - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [MAXS-1:0]  last_w;
  logic [MAXS-1:0]  cnt_w;

  assign last_w = div_last(NST, cur);

  always_comb begin
    cnt_w = '0;
    cnt_w[DIV_W-1:0] = cnt_q;
  end

  assign clk_en = (cnt_w == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || clk_en)  cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

  a_r7_no_double_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !restart && int'(cur) != NST-1) |=> !clk_en);
endmodule

// File: rtl/occ_clk_sel.sv
`timescale 1ns/1ps
module occ_clk_sel
  import ocs_pkg::*;
#(
  parameter int NST   = 10,
  parameter int OCC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_level,
  input  logic             thr_wr_en,
  input  logic [3:0]       thr_wr_idx,
  input  logic [OCC_W-1:0] thr_wr_val,
  input  logic [NST-1:0]   state_mask,
  output logic             clk_en,
  output logic [3:0]       state_idx
);
  logic [NST-2:0][OCC_W-1:0] thr_q;
  idx_t cur_q;
  logic cur_chg, ev_up, ev_dn, ev_align;

  ocs_thr_bank #(.NST(NST), .OCC_W(OCC_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en), .wr_idx(thr_wr_idx),
    .wr_val(thr_wr_val), .thr_q(thr_q)
  );

  ocs_step_ctrl #(.NST(NST), .OCC_W(OCC_W)) u_step (
    .clk(clk), .rst_n(rst_n), .occ(occ_level), .thr_q(thr_q), .en(state_mask),
    .cur_q(cur_q), .cur_chg(cur_chg), .ev_up(ev_up), .ev_dn(ev_dn),
    .ev_align(ev_align)
  );

  ocs_rate_div #(.NST(NST)) u_div (
    .clk(clk), .rst_n(rst_n), .cur(cur_q), .restart(cur_chg), .clk_en(clk_en)
  );

  assign state_idx = cur_q;

  // R1: reset holds state 0 with no pulse
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (state_idx == 4'd0 && !clk_en)));
endmodule

// File: tb/occ_clk_sel_tb_top.sv
`timescale 1ns/1ps
module occ_clk_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NST   = 10;
  localparam int OCC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OCC_W-1:0] occ_level = '0;
  logic thr_wr_en = 1'b0;
  logic [3:0] thr_wr_idx = '0;
  logic [OCC_W-1:0] thr_wr_val = '0;
  logic [NST-1:0] state_mask = '1;
  logic clk_en;
  logic [3:0] state_idx;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_clk_sel #(.NST(NST), .OCC_W(OCC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .occ_level(occ_level), .thr_wr_en(thr_wr_en),
    .thr_wr_idx(thr_wr_idx), .thr_wr_val(thr_wr_val), .state_mask(state_mask),
    .clk_en(clk_en), .state_idx(state_idx)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    m_cur = 0, m_cnt = 0;
  int    m_thr[NST-1];
  string m_why = "R1";
  bit    m_chg = 1'b0;

  function automatic int period_of(int s);
    return 1 << (NST - 1 - s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_cnt = 0; m_chg = 1'b0; m_why = "R1";
      foreach (m_thr[k]) m_thr[k] = (1 << OCC_W) - 1;
    end else begin
      int nxt, lowest, above, below;
      nxt = m_cur; m_why = "R9";
      lowest = -1; above = -1; below = -1;
      for (int k = NST-1; k >= 0; k--) if (state_mask[k]) lowest = k;
      for (int k = NST-1; k > m_cur; k--) if (state_mask[k]) above = k;
      for (int k = 0; k < m_cur; k++) if (state_mask[k]) below = k;
      if (!state_mask[m_cur]) begin
        if (lowest >= 0) begin nxt = lowest; m_why = "R1"; end
        else m_why = "R5";
      end else if (above >= 0 && int'(occ_level) > m_thr[m_cur]) begin
        nxt = above; m_why = (above > m_cur + 1) ? "R5" : "R3";
      end else if (below >= 0 && int'(occ_level) <= m_thr[below]) begin
        nxt = below; m_why = (below < m_cur - 1) ? "R5" : "R4";
      end
      m_chg = (nxt != m_cur);
      if (m_chg) m_cnt = 0;
      else if (m_cnt == period_of(m_cur) - 1) m_cnt = 0;
      else m_cnt++;
      if (thr_wr_en && int'(thr_wr_idx) < NST-1) m_thr[thr_wr_idx] = int'(thr_wr_val);
      m_cur = nxt;
    end
  end

  // per-cycle comparison, away from the active edge
  int prev_state = 0;
  logic [NST-1:0] prev_mask = '1;
  always @(negedge clk) begin
    if (cmp_on) begin
      bit exp_en;
      exp_en = rst_n && (m_cnt == period_of(m_cur) - 1);
      chk(int'(state_idx) == m_cur, m_why, "state_idx", int'(state_idx), m_cur);
      chk(clk_en == exp_en, m_chg ? "R8" : "R7", "clk_en", int'(clk_en), int'(exp_en));
      if (rst_n && int'(state_idx) != prev_state && prev_mask == state_mask &&
          state_mask[prev_state]) begin
        int between;
        between = 0;
        for (int k = 0; k < NST; k++)
          if (state_mask[k] &&
              ((k > prev_state && k < int'(state_idx)) ||
               (k < prev_state && k > int'(state_idx)))) between++;
        chk(between == 0, "R6", "enabled states passed over", between, 0);
      end
    end
    prev_state = int'(state_idx);
    prev_mask  = state_mask;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_thr(int idx, int val);
    thr_wr_en = 1'b1; thr_wr_idx = 4'(idx); thr_wr_val = OCC_W'(val);
    @(negedge clk);
    thr_wr_en = 1'b0;
  endtask

  initial begin
    int occ_i;
    step(3);
    cmp_on = 1'b1;
    chk(state_idx == 4'd0 && !clk_en, "R1", "state in reset", int'(state_idx), 0);
    rst_n = 1'b1;
    step(1);
    chk(state_idx == 4'd0, "R1", "lowest enabled after reset", int'(state_idx), 0);

    occ_level = 8'd255;
    step(5);
    chk(state_idx == 4'd0, "R2", "no climb on reset thresholds", int'(state_idx), 0);
    occ_level = 8'd0;
    for (int i = 0; i < NST-1; i++) wr_thr(i, (i + 1) * 20);

    occ_level = 8'd200;
    step(1);
    chk(state_idx == 4'd1, "R6", "one step per cycle", int'(state_idx), 1);
    step(8);
    chk(state_idx == 4'd9, "R3", "climb to top", int'(state_idx), 9);
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk(clk_en == 1'b1, "R7", "top state enable high", int'(clk_en), 1);
    end

    occ_level = 8'd0;
    step(1);
    chk(state_idx == 4'd8, "R4", "step down", int'(state_idx), 8);
    step(20);
    chk(state_idx == 4'd0, "R4", "back to bottom", int'(state_idx), 0);

    state_mask = 10'b11_1001_0000;
    step(1);
    chk(state_idx == 4'd4, "R1", "realign to lowest enabled", int'(state_idx), 4);
    occ_level = 8'd101;
    step(1);
    chk(state_idx == 4'd7, "R5", "skip disabled states", int'(state_idx), 7);
    step(1);
    chk(state_idx == 4'd7, "R3", "hold below threshold", int'(state_idx), 7);
    wr_thr(7, 90);
    chk(state_idx == 4'd7, "R2", "old threshold used on write edge", int'(state_idx), 7);
    step(1);
    chk(state_idx == 4'd8, "R2", "rewritten threshold used", int'(state_idx), 8);
    wr_thr(7, 160);

    state_mask = '1;
    occ_level  = 8'd130;
    begin
      int waited;
      waited = 0;
      while (state_idx != 4'd6 && waited < 12) begin step(1); waited++; end
      chk(state_idx == 4'd6, "R4", "settle in state 6", int'(state_idx), 6);
      chk(clk_en == 1'b0, "R8", "no pulse in first cycle", int'(clk_en), 0);
      for (int c = 2; c <= 8; c++) begin
        step(1);
        chk(clk_en == (c == 8), "R8", "first pulse at full period", int'(clk_en), int'(c == 8));
      end
    end

    state_mask = '0;
    occ_level  = 8'd0;
    step(6);
    chk(state_idx == 4'd6, "R5", "empty mask holds", int'(state_idx), 6);
    state_mask = '1;

    occ_i = 128;
    for (int cyc = 0; cyc < 30000; cyc++) begin
      occ_i += int'($urandom_range(0, 8)) - 4;
      if (occ_i < 0) occ_i = 0;
      if (occ_i > 255) occ_i = 255;
      occ_level = 8'(occ_i);
      if (cyc % 700 == 350) begin
        thr_wr_en  = 1'b1;
        thr_wr_idx = 4'($urandom_range(0, 12));
        thr_wr_val = 8'($urandom_range(0, 255));
      end else thr_wr_en = 1'b0;
      if (cyc % 4000 == 2000) state_mask = 10'($urandom_range(0, 1023));
      step(1);
    end
    thr_wr_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule